// File: doc/BRIEF.md
# Header-Coded Two-Wire Camera Register Slave

This block is the control port of an image sensor. An external master drives a two-wire bus in the usual open-drain style. The block samples both lines with the core clock, decodes fixed-length messages and keeps the sensor's twelve-bit control registers. A write message carries two bytes after the device address. The top four bits of the first byte are a header code that chooses the register. The remaining four bits and the whole second byte make up the twelve-bit value. A read message always returns a 32-bit status word of four bytes. That word shows either the exposure, gain and mode state or the exposure monitor results, depending on a select bit in the second setup register.

A message ends on its own once its last byte has been acknowledged, so a stop condition is not needed. A write to coarse exposure, fine exposure or gain starts a lockout period. During that period the device does not answer its own address. The length of the period is a parameter for each of the two field-rate modes. Two strap pins set the low address bits, which lets four sensors share one bus.

Top module: `cam2w_slave`

## Requirements
- R1: The device acknowledges only the 7-bit address {00100, strap_i[1], strap_i[0]}, where bit 0 of the address byte is the read flag. For any other address it leaves SDA released for the rest of the message.
- R2: A write consists of the address and then two bytes. Bits 7:4 of the first byte are the header. Bits 3:0 of the first byte, followed by the second byte, form the 12-bit value. The chosen register takes this value once the second byte has been received. Each data byte is acknowledged.
- R3: Headers 1, 2, 3, 4, 5, 8, 9, A and E select the registers setup-1, setup-2, coarse exposure, fine exposure, gain, T1, T2, analogue control and setup-3. Registers are exposed on regs_o, with slot k at bits [12k+11:12k] in that order. Every other header, including 0, gets a NACK on the first data byte and changes no register.
- R4: After reset, setup-1 holds 0x094 and every other register holds 0. The setup-1 fields are: bit 0 backlit, bit 1 linear, bit 2 auto gain, bit 3 black-calibration inhibit, bit 4 auto exposure, bits 6:5 shuffle, bit 7 force calibration, bits 9:8 clock divide.
- R5: When setup-2 bit 3 is 0, a read returns four bytes, most significant first. The layout is: [31:23] coarse[8:0], [22:14] fine[8:0], [13:10] gain[3:0], [9] setup-1 bit 4, [8] setup-1 bit 3, [7] setup-1 bit 2, [6] setup-1 bit 1, [5] backlit_pin_i, [4] zero, [3:0] TYPE_ID.
- R6: When setup-2 bit 3 is 1, the read word has [17] = mon_busy_i, [16:0] = white_cnt_i and all other bits zero.
- R7: The interface returns to idle after the final acknowledged byte of a message, without a stop. Further bytes clocked without a new start are not acknowledged and do not write.
- R8: A write to coarse exposure, fine exposure or gain starts a lockout. The lockout lasts BUSY50_CYC clocks when mode60_i is 0 and BUSY60_CYC clocks when mode60_i is 1, with mode60_i sampled at the write. During the lockout the address is not acknowledged. After the lockout it is acknowledged again.
- R9: If the master NACKs a read byte, the device releases SDA and drives nothing further until a new start.
- R10: A stop condition at any point abandons the current message. An unfinished write leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Low two device address bits |
| mode60_i | input | 1 | 1 selects the 60 Hz lockout length |
| backlit_pin_i | input | 1 | Backlit pin level, reported in the read word |
| mon_busy_i | input | 1 | Black-level monitor running |
| white_cnt_i | input | 17 | White pixel count |
| regs_o | output | 108 | Nine 12-bit registers, slot 0 in the low bits |

## Verification
The bench builds the block with BUSY50_CYC = 400, BUSY60_CYC = 1200, TYPE_ID = 0xB and the straps tied to 10. With lockouts this short, a single run can see a refused address inside each lockout and an accepted address after it. A probe made 400 to 1200 clocks after a write in 60 Hz mode shows that the two lengths really differ. Bus messages are driven at twenty clocks per bit, which leaves the synchroniser and edge-detect delay well inside each half bit.

// File: rtl/cam2w_pkg.sv
package cam2w_pkg;
    localparam int DATA_W = 12;
    localparam int NREG   = 9;
    localparam int SLOT_W = $clog2(NREG);
    localparam logic [4:0] DEV_BASE  = 5'b00100;
    localparam int         SEC_SEL   = 3;
    localparam logic [DATA_W-1:0] SETUP1_RST = 12'h094;

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_WRITE, L_ACK, L_READ, L_MACK
    } link_st_e;

    // returns {valid, slot}
    function automatic logic [SLOT_W:0] hdr_decode(input logic [3:0] h);
        case (h)
            4'h1: return {1'b1, SLOT_W'(0)};
            4'h2: return {1'b1, SLOT_W'(1)};
            4'h3: return {1'b1, SLOT_W'(2)};
            4'h4: return {1'b1, SLOT_W'(3)};
            4'h5: return {1'b1, SLOT_W'(4)};
            4'h8: return {1'b1, SLOT_W'(5)};
            4'h9: return {1'b1, SLOT_W'(6)};
            4'hA: return {1'b1, SLOT_W'(7)};
            4'hE: return {1'b1, SLOT_W'(8)};
            default: return '0;
        endcase
    endfunction

    function automatic logic hdr_is_exposure(input logic [3:0] h);
        return (h == 4'h3) || (h == 4'h4) || (h == 4'h5);
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int slot);
        return (slot == 0) ? SETUP1_RST : '0;
    endfunction
endpackage

// File: rtl/cam2w_sync.sv
module cam2w_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/cam2w_regs.sv
module cam2w_regs
    import cam2w_pkg::*;
#(
    parameter int BUSY50_CYC = 1_700_000,
    parameter int BUSY60_CYC = 2_000_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [3:0]                   wr_hdr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         mode60_i,
    output logic [NREG-1:0][DATA_W-1:0]  regs_o,
    output logic                         busy_o
);
    localparam int BUSY_MAX = (BUSY50_CYC > BUSY60_CYC) ? BUSY50_CYC : BUSY60_CYC;
    localparam int CNT_W    = $clog2(BUSY_MAX + 1);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [CNT_W-1:0]            cnt;
    } rstate_t;

    rstate_t q, d;
    logic [SLOT_W:0] dec;

    always_comb begin
        d   = q;
        dec = hdr_decode(wr_hdr);
        if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
        if (wr_en && dec[SLOT_W]) begin
            for (int i = 0; i < NREG; i++)
                if (dec[SLOT_W-1:0] == SLOT_W'(i)) d.regs[i] = wr_data;
            if (hdr_is_exposure(wr_hdr))
                d.cnt = mode60_i ? CNT_W'(BUSY60_CYC) : CNT_W'(BUSY50_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q.regs[i] <= reg_reset(i);
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign regs_o = q.regs;
    assign busy_o = (q.cnt != '0);

    a_r8_busy_after_expo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hdr_is_exposure(wr_hdr)) |=> busy_o);
    a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_en);
    a_r2_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q.regs));
endmodule

// File: rtl/cam2w_link.sv
module cam2w_link
    import cam2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    input  logic [31:0]       rd_word_i,
    output logic              sda_pull_o,
    output logic              wr_en_o,
    output logic [3:0]        wr_hdr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    typedef struct packed {
        link_st_e    st;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic [1:0]  nbyte;
        logic [31:0] word;
        logic        rd;
        logic        last;
        logic        pull;
        logic        mnack;
        logic [3:0]  hdr;
        logic [3:0]  nib;
        logic        scl_p;
        logic        sda_p;
        logic        wr;
    } lstate_t;

    lstate_t q, d;
    logic rise, fall, start, stop;
    logic [SLOT_W:0] dec;

    assign rise  = scl_i & ~q.scl_p;
    assign fall  = ~scl_i & q.scl_p;
    assign start = scl_i & q.scl_p & q.sda_p & ~sda_i;
    assign stop  = scl_i & q.scl_p & ~q.sda_p & sda_i;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.scl_p = scl_i;
        d.sda_p = sda_i;
        dec     = hdr_decode(q.sh[7:4]);
        if (start) begin
            d.st = L_ADDR; d.bits = '0; d.pull = 1'b0; d.nbyte = '0;
        end else if (stop) begin
            d.st = L_IDLE; d.pull = 1'b0;
        end else begin
            case (q.st)
                L_ADDR, L_WRITE: begin
                    if (rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_i};
                        d.bits = q.bits + 4'd1;
                    end
                    if (fall && q.bits == 4'd8) begin
                        if (q.st == L_ADDR) begin
                            if (q.sh[7:1] == {DEV_BASE, strap_i} && !busy_i) begin
                                d.st = L_ACK; d.pull = 1'b1; d.rd = q.sh[0];
                                d.last = 1'b0; d.word = rd_word_i;
                            end else begin
                                d.st = L_IDLE;
                            end
                        end else if (q.nbyte == 2'd0) begin
                            if (dec[SLOT_W]) begin
                                d.hdr = q.sh[7:4]; d.nib = q.sh[3:0];
                                d.st = L_ACK; d.pull = 1'b1; d.nbyte = 2'd1;
                            end else begin
                                d.st = L_IDLE;
                            end
                        end else begin
                            d.wr = 1'b1; d.st = L_ACK; d.pull = 1'b1; d.last = 1'b1;
                        end
                    end
                end
                L_ACK: if (fall) begin
                    d.bits = '0;
                    if (q.last) begin
                        d.st = L_IDLE; d.pull = 1'b0;
                    end else if (q.rd) begin
                        d.st = L_READ; d.pull = ~q.word[31]; d.word = {q.word[30:0], 1'b0};
                    end else begin
                        d.st = L_WRITE; d.pull = 1'b0;
                    end
                end
                L_READ: begin
                    if (rise) d.bits = q.bits + 4'd1;
                    if (fall) begin
                        if (q.bits == 4'd8) begin
                            d.st = L_MACK; d.pull = 1'b0;
                        end else begin
                            d.pull = ~q.word[31]; d.word = {q.word[30:0], 1'b0};
                        end
                    end
                end
                L_MACK: begin
                    if (rise) d.mnack = sda_i;
                    if (fall) begin
                        if (q.mnack || q.nbyte == 2'd3) begin
                            d.st = L_IDLE;
                        end else begin
                            d.nbyte = q.nbyte + 2'd1; d.st = L_READ; d.bits = '0;
                            d.pull = ~q.word[31]; d.word = {q.word[30:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= L_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign wr_en_o    = q.wr;
    assign wr_hdr_o   = q.hdr;
    assign wr_data_o  = {q.nib, q.sh};

    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (q.st == L_IDLE) && !q.pull);
    a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == L_ADDR && fall && q.bits == 4'd8 && busy_i) |=> !q.pull);
    a_r9_mnack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == L_MACK && fall && q.mnack) |=> (q.st == L_IDLE) && !q.pull);
    a_r7_pull_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        q.pull |-> (q.st != L_IDLE));
endmodule

// File: rtl/cam2w_slave.sv
module cam2w_slave
    import cam2w_pkg::*;
#(
    parameter int         BUSY50_CYC = 1_700_000,
    parameter int         BUSY60_CYC = 2_000_000,
    parameter logic [3:0] TYPE_ID    = 4'h4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_pull_o,
    input  logic [1:0]               strap_i,
    input  logic                     mode60_i,
    input  logic                     backlit_pin_i,
    input  logic                     mon_busy_i,
    input  logic [16:0]              white_cnt_i,
    output logic [NREG*DATA_W-1:0]   regs_o
);
    logic [1:0]                  bus_s;
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic                        busy, wr_en;
    logic [3:0]                  wr_hdr;
    logic [DATA_W-1:0]           wr_data;
    logic [31:0]                 rd_word;

    cam2w_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(bus_s));

    always_comb begin
        if (regs[1][SEC_SEL])
            rd_word = {14'd0, mon_busy_i, white_cnt_i};
        else
            rd_word = {regs[2][8:0], regs[3][8:0], regs[4][3:0],
                       regs[0][4], regs[0][3], regs[0][2], regs[0][1],
                       backlit_pin_i, 1'b0, TYPE_ID};
    end

    cam2w_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_i(bus_s[1]), .sda_i(bus_s[0]),
        .strap_i(strap_i), .busy_i(busy), .rd_word_i(rd_word),
        .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_hdr_o(wr_hdr),
        .wr_data_o(wr_data));

    cam2w_regs #(.BUSY50_CYC(BUSY50_CYC), .BUSY60_CYC(BUSY60_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hdr(wr_hdr),
        .wr_data(wr_data), .mode60_i(mode60_i), .regs_o(regs), .busy_o(busy));

    assign regs_o = regs;
endmodule

// File: tb/sim_cam2w_slave.sv
module sim_cam2w_slave;
    localparam int HALF = 10;
    localparam int B50  = 400;
    localparam int B60  = 1200;
    localparam logic [3:0] TID = 4'hB;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] AW = {5'b00100, STRAP, 1'b0};
    localparam logic [7:0] AR = {5'b00100, STRAP, 1'b1};
    localparam int NV = 13;
    // {header, data, expected header ack}
    localparam logic [16:0] VEC [NV] = '{
        {4'h1, 12'h0A5, 1'b1}, {4'h2, 12'h124, 1'b1}, {4'h8, 12'h5A5, 1'b1},
        {4'h9, 12'hFFF, 1'b1}, {4'hA, 12'h3C3, 1'b1}, {4'hE, 12'h801, 1'b1},
        {4'h0, 12'h123, 1'b0}, {4'h6, 12'h456, 1'b0}, {4'hF, 12'h789, 1'b0},
        {4'h7, 12'hABC, 1'b0}, {4'h3, 12'h1AB, 1'b1}, {4'h4, 12'h0CD, 1'b1},
        {4'h5, 12'h007, 1'b1}};

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic mode60 = 0, backlit = 1, mon_busy = 0;
    logic [16:0] white = '0;
    logic sda_pull;
    logic [107:0] regs;
    wire sda_line = sda_m & ~sda_pull;
    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [11:0] mdl [9];

    always #4 clk = ~clk;

    cam2w_slave #(.BUSY50_CYC(B50), .BUSY60_CYC(B60), .TYPE_ID(TID)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(STRAP), .mode60_i(mode60),
        .backlit_pin_i(backlit), .mon_busy_i(mon_busy), .white_cnt_i(white),
        .regs_o(regs));

    function automatic int slot_of(input logic [3:0] h);
        case (h)
            4'h1: return 0; 4'h2: return 1; 4'h3: return 2; 4'h4: return 3;
            4'h5: return 4; 4'h8: return 5; 4'h9: return 6; 4'hA: return 7;
            4'hE: return 8; default: return -1;
        endcase
    endfunction

    function automatic logic [107:0] mdl_flat();
        logic [107:0] f;
        for (int k = 0; k < 9; k++) f[k*12 +: 12] = mdl[k];
        return f;
    endfunction

    function automatic logic [31:0] primary();
        return {mdl[2][8:0], mdl[3][8:0], mdl[4][3:0], mdl[0][4], mdl[0][3],
                mdl[0][2], mdl[0][1], backlit, 1'b0, TID};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic m_start();
        sda_m = 1; tick(HALF); scl_m = 1; tick(HALF);
        sda_m = 0; tick(HALF); scl_m = 0; tick(HALF);
    endtask

    task automatic m_stop();
        sda_m = 0; tick(HALF); scl_m = 1; tick(HALF); sda_m = 1; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(HALF); scl_m = 1; tick(HALF); scl_m = 0; tick(2);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1; tick(HALF); scl_m = 1; tick(HALF/2);
        b = sda_line; tick(HALF/2); scl_m = 0; tick(2);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
        send_bit(~mack);
    endtask

    task automatic do_write(input logic [3:0] h, input logic [11:0] v,
                            output logic a0, output logic a1, output logic a2);
        a1 = 0; a2 = 0;
        m_start();
        wbyte(AW, a0);
        if (a0) wbyte({h, v[11:8]}, a1);
        if (a1) wbyte(v[7:0], a2);
        m_stop();
    endtask

    task automatic do_read(output logic a, output logic [31:0] w);
        w = '0;
        m_start();
        wbyte(AR, a);
        if (a) begin
            rbyte(w[31:24], 1); rbyte(w[23:16], 1);
            rbyte(w[15:8], 1);  rbyte(w[7:0], 0);
        end
        m_stop();
    endtask

    task automatic probe(output logic a);
        m_start(); wbyte(AW, a); m_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a;
        logic [31:0] w;
        logic [7:0] b;
        for (int k = 0; k < 9; k++) mdl[k] = '0;
        mdl[0] = 12'h094;
        tick(10); rst_n = 1; tick(5);

        // R4 reset values
        chk("R4 reset regs", regs, mdl_flat());
        chk("R4 sda idle", sda_pull, 0);

        // R2/R3 vector table
        for (int v = 0; v < NV; v++) begin
            logic [3:0] h; logic [11:0] dv; logic ea;
            {h, dv, ea} = VEC[v];
            do_write(h, dv, a0, a1, a2);
            chk("R1 addr ack", a0, 1);
            chk("R3 header ack", a1, ea);
            if (ea) begin
                chk("R2 data ack", a2, 1);
                mdl[slot_of(h)] = dv;
            end
            chk("R2 R3 regs after write", regs, mdl_flat());
            if (h == 4'h3 || h == 4'h4 || h == 4'h5) tick(B60 + 100);
        end

        // R1 foreign addresses
        m_start(); wbyte({5'b00100, 2'b01, 1'b0}, a); m_stop();
        chk("R1 other strap nack", a, 0);
        m_start(); wbyte(8'h60, a); m_stop();
        chk("R1 other base nack", a, 0);

        // R5 primary read
        do_read(a, w);
        chk("R5 read ack", a, 1);
        chk("R5 primary word", w, primary());
        backlit = 0;
        do_read(a, w);
        chk("R5 backlit pin bit", w, primary());

        // R6 secondary read
        do_write(4'h2, 12'h008, a0, a1, a2); mdl[1] = 12'h008;
        mon_busy = 1; white = 17'h1A5C3;
        do_read(a, w);
        chk("R6 secondary busy", w, {14'd0, 1'b1, 17'h1A5C3});
        mon_busy = 0; white = 17'h00F0F;
        do_read(a, w);
        chk("R6 secondary idle", w, {14'd0, 1'b0, 17'h00F0F});
        do_write(4'h2, 12'h000, a0, a1, a2); mdl[1] = 12'h000;

        // R9 master nack ends read
        m_start(); wbyte(AR, a); rbyte(b, 0);
        chk("R9 first byte", b, primary()[31:24]);
        rbyte(b, 0);
        chk("R9 released after nack", b, 8'hFF);
        m_stop();

        // R7 auto idle after last byte
        m_start(); wbyte(AW, a0); wbyte({4'hE, 4'h0}, a1); wbyte(8'hF0, a2);
        mdl[8] = 12'h0F0;
        wbyte({4'hE, 4'h5}, a);
        chk("R7 extra byte not acked", a, 0);
        wbyte(8'h55, a);
        m_stop();
        chk("R7 no extra write", regs, mdl_flat());

        // R10 stop mid write
        m_start(); wbyte(AW, a0); wbyte({4'h8, 4'h1}, a1); m_stop();
        chk("R10 header acked", a1, 1);
        chk("R10 abandoned write", regs, mdl_flat());

        // R8 lockout, 50 Hz
        mode60 = 0;
        do_write(4'h3, 12'h055, a0, a1, a2); mdl[2] = 12'h055;
        probe(a);
        chk("R8 busy nack 50", a, 0);
        tick(B50 + 100);
        probe(a);
        chk("R8 free ack 50", a, 1);

        // R8 lockout, 60 Hz
        mode60 = 1;
        do_write(4'h5, 12'h003, a0, a1, a2); mdl[4] = 12'h003;
        mode60 = 0;
        tick(B50 + 50);
        probe(a);
        chk("R8 still busy 60", a, 0);
        tick(B60);
        probe(a);
        chk("R8 free ack 60", a, 1);
        chk("R8 regs after lockout", regs, mdl_flat());

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule